// File: doc/BRIEF.md
# Downward Ramp ADC Controller

This block sequences a counting analog-to-digital conversion that starts at full scale and walks downward. It presents a code to an external DAC, lets an external comparator judge the DAC voltage against an unknown input, and keeps stepping the code down by one until the comparator reports that the DAC has reached or passed below the unknown. The DAC, the comparator and any display sit outside the block. The block only sees the comparator's single output bit.

A conversion begins when `start` is pulsed. After every change of the DAC code, the controller holds the code for a programmable settling window (`SETTLE_CYC` cycles, default 20) before it samples the comparator. This covers the comparator's propagation delay. When it stops, it copies the final code into `result` and raises `done` for one cycle. The result then holds until the next start. The code never wraps: if the code reaches zero and the comparator still reads low, the conversion ends at zero. A `start` during a conversion abandons it and begins again from full scale.

Top module: `ramp_adc`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `dac_code` is all ones (255 for WIDTH=8), `result` is 0 and `done` is 0.
- R2: In the cycle after `start` is sampled high, `dac_code` is all ones.
- R3: Each DAC code is held for SETTLE_CYC+1 cycles before the next one, and the first comparator sample falls SETTLE_CYC cycles after the load cycle. With k decrements, `done` is seen 1+SETTLE_CYC+k*(SETTLE_CYC+1) clock edges after the edge that samples `start`.
- R4: When the sampled comparator bit is 0 and the code is not zero, the code decreases by exactly one. Apart from a load by `start`, `dac_code` changes in no other way.
- R5: When the sampled comparator bit is 1, the conversion ends. `result` takes the current `dac_code` and `done` rises in the same cycle.
- R6: If the code is 0 and the comparator bit is still 0 at the sample, the conversion ends with `result` = 0. The code does not wrap to full scale.
- R7: `done` is high for exactly one cycle per conversion.
- R8: After `done`, `result` and `dac_code` stay constant and `done` stays low until the next `start`, whatever the comparator bit does.
- R9: A `start` during a conversion restarts it from full scale. No `done` comes from the abandoned conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins (or restarts) a conversion |
| cmp_hi | input | 1 | Comparator bit, 1 when the DAC voltage is at or below the unknown |
| dac_code | output | WIDTH | Code driven to the external DAC |
| result | output | WIDTH | Final code of the last conversion |
| done | output | 1 | One-cycle strobe marking a new result |

## Verification
The assertions assume that `start` is only a short pulse, and that `cmp_hi` follows the DAC code monotonically: once the code is low enough, the bit reads 1 at every lower code. The bench models the comparator as `dac_code <= unknown`, with one stuck-low case for the zero floor. It disturbs the comparator only while the block is holding a finished result, so the inputs keep within those assumptions.

// File: rtl/ramp_adc_pkg.sv
// Package: shared types for the downward ramp ADC controller.
// Assumes nothing beyond a two-bit state encoding.
package ramp_adc_pkg;

    // Controller phases: load full scale, settle, step down, hold result
    typedef enum logic [1:0] {
        PH_LOAD   = 2'd0,
        PH_SETTLE = 2'd1,
        PH_STEP   = 2'd2,
        PH_HOLD   = 2'd3
    } ramp_phase_e;

endpackage

// File: rtl/ramp_settle_timer.sv
// Settling timer: reloads to SETTLE_CYC-1 on request, then counts down to
// zero and stays there. Assumes SETTLE_CYC >= 1.
module ramp_settle_timer #(
    parameter int SETTLE_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    output logic expired
);
    localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [CW-1:0] RELOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (reload)
            cnt_q <= RELOAD_VAL;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ramp_code_reg.sv
// Code and result registers: holds the DAC code (loaded to full scale,
// decremented with a floor at zero) and captures the result with a strobe.
// Assumes load has priority over decrement.
module ramp_code_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic             capture,
    output logic [WIDTH-1:0] code,
    output logic             code_zero,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    localparam logic [WIDTH-1:0] FULL_SCALE = '1;

    assign code_zero = (code == '0);

    // DAC code: full scale on reset or load, step down otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || load)
            code <= FULL_SCALE;
        else if (dec && !code_zero)
            code <= code - 1'b1;
    end

    // Result latch and one-cycle completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result <= '0;
            done   <= 1'b0;
        end else begin
            done <= capture;
            if (capture)
                result <= code;
        end
    end
endmodule

// File: rtl/ramp_ctrl_fsm.sv
// Sequencer: walks load -> settle -> (step -> settle)* -> hold. Start from
// any phase restarts. Assumes the comparator has settled once the timer expires.
module ramp_ctrl_fsm
    import ramp_adc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic cmp_hi,
    input  logic settle_expired,
    input  logic code_zero,
    output logic timer_reload,
    output logic code_dec,
    output logic capture
);
    ramp_phase_e phase_q, phase_d;
    logic        finish;

    assign finish = (phase_q == PH_SETTLE) && settle_expired && (cmp_hi || code_zero);

    // Next-phase decision
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOAD:   phase_d = PH_SETTLE;
            PH_SETTLE: if (settle_expired) phase_d = (cmp_hi || code_zero) ? PH_HOLD : PH_STEP;
            PH_STEP:   phase_d = PH_SETTLE;
            PH_HOLD:   phase_d = PH_HOLD;
            default:   phase_d = PH_HOLD;
        endcase
        if (start)
            phase_d = PH_LOAD;
    end

    // Phase register, idle in hold after reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= PH_HOLD;
        else
            phase_q <= phase_d;
    end

    assign timer_reload = (phase_q == PH_LOAD) || (phase_q == PH_STEP);
    assign code_dec     = (phase_q == PH_STEP) && !start;
    assign capture      = finish && !start;
endmodule

// File: rtl/ramp_adc.sv
// Top: downward ramp ADC controller. Drives a code to an external DAC,
// waits SETTLE_CYC cycles after every change, samples the comparator and
// either steps down or reports. Assumes cmp_hi is synchronous to clk.
module ramp_adc #(
    parameter int WIDTH      = 8,
    parameter int SETTLE_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] dac_code,
    output logic [WIDTH-1:0] result,
    output logic             done
);
    logic settle_expired;
    logic timer_reload;
    logic code_dec;
    logic capture;
    logic code_zero;

    ramp_ctrl_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .cmp_hi         (cmp_hi),
        .settle_expired (settle_expired),
        .code_zero      (code_zero),
        .timer_reload   (timer_reload),
        .code_dec       (code_dec),
        .capture        (capture)
    );

    ramp_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (timer_reload),
        .expired (settle_expired)
    );

    ramp_code_reg #(.WIDTH(WIDTH)) u_code (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .dec       (code_dec),
        .capture   (capture),
        .code      (dac_code),
        .code_zero (code_zero),
        .result    (result),
        .done      (done)
    );
endmodule

// File: rtl/ramp_adc_chk.sv
// Checker: temporal properties on the ramp ADC ports. Assumes start is a
// pulse and the comparator is monotonic in the code.
module ramp_adc_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             done,
    input logic [WIDTH-1:0] dac_code,
    input logic [WIDTH-1:0] result
);
    // R2
    start_loads_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (dac_code == {WIDTH{1'b1}}));

    // R4
    step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && dac_code != '0) |=>
            (dac_code == $past(dac_code)) || (dac_code == $past(dac_code) - 1'b1));

    // R6
    zero_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && dac_code == '0) |=> (dac_code == '0));

    // R5
    result_matches_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (result == dac_code));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);
endmodule

bind ramp_adc ramp_adc_chk #(.WIDTH(WIDTH)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .dac_code (dac_code),
    .result   (result)
);

// File: tb/ramp_adc_tb_top.sv
// Bench: sweeps unknown levels across the code range with a short settle
// window and checks results and latency arithmetically.
module ramp_adc_tb_top;
    localparam int W = 8;
    localparam int S = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         stuck_low = 1'b0;
    logic         noise_en = 1'b0;
    logic         noise_val = 1'b0;
    int           unknown = 0;
    logic         cmp_hi;
    logic [W-1:0] dac_code, result;
    logic         done;
    int           n_tests = 0, n_fail = 0;
    int           cycles = 0;

    always #5 clk = ~clk;

    assign cmp_hi = noise_en ? noise_val : (stuck_low ? 1'b0 : (int'(dac_code) <= unknown));

    ramp_adc #(.WIDTH(W), .SETTLE_CYC(S)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_hi(cmp_hi),
        .dac_code(dac_code), .result(result), .done(done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    // One conversion: pulse start, count edges until done
    task automatic convert(input int u, input bit stuck, input bit full);
        int lat = 0;
        int k;
        unknown = u;
        stuck_low = stuck;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (full) check(dac_code == 8'hFF, "R2 load", dac_code, 255);
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
        k = stuck ? 255 : 255 - u;
        check(done, "R5 done seen", done, 1);
        check(int'(result) == (stuck ? 0 : u), stuck ? "R6 floor result" : "R5 result", result, stuck ? 0 : u);
        if (full) check(lat == 1 + S + k * (S + 1), "R3 latency", lat, 1 + S + k * (S + 1));
        @(negedge clk);
        check(!done, "R7 strobe width", done, 0);
    endtask

    initial begin
        @(negedge clk);
        check(dac_code == 8'hFF && result == 0 && !done, "R1 reset", dac_code, 255);
        @(negedge clk);
        rst_n = 1'b1;
        check(dac_code == 8'hFF && result == 0 && !done, "R1 after reset", {result, dac_code}, 255);

        // R3 R4 R5: sweep of unknown levels
        for (int u = 0; u < 256; u += 5) convert(u, 1'b0, 1'b1);
        convert(254, 1'b0, 1'b1);
        convert(255, 1'b0, 1'b1);
        convert(1, 1'b0, 1'b1);

        // R6: comparator never trips
        convert(0, 1'b1, 1'b1);
        stuck_low = 1'b0;

        // R8: comparator noise after done is ignored
        convert(77, 1'b0, 1'b1);
        begin
            bit held = 1'b1;
            noise_en = 1'b1;
            for (int i = 0; i < 40; i++) begin
                noise_val = i[0];
                @(negedge clk);
                if (done || result != 8'd77 || dac_code != 8'd77) held = 1'b0;
            end
            noise_en = 1'b0;
            check(held, "R8 hold", result, 77);
        end

        // R9: restart mid-conversion
        unknown = 100;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit early = 1'b0;
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                if (done) early = 1'b1;
            end
            check(!early, "R9 no early done", early, 0);
        end
        convert(100, 1'b0, 1'b1);

        finish_run();
    end
endmodule